// File: doc/BRIEF.md
# Oversampled Serial Receive Framer

This block turns an asynchronous serial line into received characters. A free-running divisor counter produces an enable at sixteen times the bit rate. The framer hunts for a falling edge on the synchronised line and confirms the start bit at mid-bit. It then takes one sample near the middle of every following bit and assembles 5 to 8 data bits, least-significant first. It optionally checks an even or odd parity bit and examines the first stop bit only.

Each finished character, together with its parity, framing and break flags, enters a 16-entry first-in first-out store. The oldest entry is always visible on the output ports, and `rd_i` removes it. The fill level is compared with a selectable trigger of 1, 4, 8 or 14 entries. That comparison drives a service request and, when flow control is enabled, drops the ready-to-send output. A time-out raises the request when characters sit unread during a long quiet period.

Top module: `rx_framer`

## Requirements
- R1: The sub-bit enable occurs once every `divisor_i` clock cycles, so one bit lasts 16×`divisor_i` cycles. A divisor of 0 stops the enable, and no character is then received.
- R2: A low level on the line is taken as a start bit only if the line is still low at the mid-bit sample. A low pulse shorter than half a bit stores nothing.
- R3: `char_len_i` selects the data length: 0, 1, 2 and 3 give 5, 6, 7 and 8 bits. Data bits are taken least-significant first, directly after the start bit. Unused upper bits of `data_o` read as 0.
- R4: With `parity_en_i`=1, the bit after the data is checked. With `parity_odd_i`=0 the data bits plus the parity bit must hold an even number of ones; with `parity_odd_i`=1 they must hold an odd number. A mismatch sets `par_err_o` for that entry. With `parity_en_i`=0, `par_err_o` is 0.
- R5: Only the first stop bit is sampled. If it is low, `frm_err_o` is set for that entry. After a low stop bit, the receiver waits for the line to go high before it hunts for a new start bit.
- R6: A character whose start, data, parity and stop samples are all low is stored once, with data 0 and both `brk_o` and `frm_err_o` set. No further entry is stored until the line returns high.
- R7: The store holds 16 entries in arrival order. The head entry is shown on `data_o`, `par_err_o`, `frm_err_o` and `brk_o`. `rd_i` removes the head entry. `level_o` gives the number of entries held, and `empty_o` is high when `level_o` is 0. `rd_i` has no effect on an empty store.
- R8: A character that completes while 16 entries are held is discarded, and `overrun_o` is set. `overrun_o` stays set until a cycle with `status_rd_i` high.
- R9: `trig_sel_i` selects the trigger level: 0, 1, 2 and 3 give 1, 4, 8 and 14 entries. `req_o` is high whenever `level_o` is at or above the trigger, or `timeout_o` is high.
- R10: `rts_o` is low when `flow_en_i`=1 and `level_o` is at or above the trigger. Otherwise it is high.
- R11: `timeout_o` goes high when the store is not empty and no character has been stored or removed for 4 character times. One character time is 16×(2 + data bits + parity bit) sub-bit enables. A store or a removal restarts the count, and an empty store clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| divisor_i | input | 16 | Clock cycles per sub-bit enable; 0 stops the enable |
| char_len_i | input | 2 | Data length select: 0, 1, 2, 3 give 5, 6, 7, 8 bits |
| parity_en_i | input | 1 | Expect a parity bit after the data |
| parity_odd_i | input | 1 | Parity sense: 1 is odd, 0 is even |
| trig_sel_i | input | 2 | Trigger level select: 0, 1, 2, 3 give 1, 4, 8, 14 entries |
| flow_en_i | input | 1 | Let the fill level drive `rts_o` |
| rx_i | input | 1 | Serial line, idle high |
| rd_i | input | 1 | Remove the head entry |
| status_rd_i | input | 1 | Clear the overrun flag |
| data_o | output | 8 | Data of the head entry |
| par_err_o | output | 1 | Parity error flag of the head entry |
| frm_err_o | output | 1 | Framing error flag of the head entry |
| brk_o | output | 1 | Break flag of the head entry |
| empty_o | output | 1 | Store holds no entry |
| level_o | output | 5 | Number of entries held |
| overrun_o | output | 1 | Sticky flag: a character was discarded because the store was full |
| req_o | output | 1 | Service request |
| timeout_o | output | 1 | Unread characters have sat through a quiet period |
| rts_o | output | 1 | High when the far end may keep sending |

## Verification
The hardest case to reach is a character that arrives while the store is completely full. To get there, the bench sends sixteen characters at the smallest divisor without reading any of them, then sends a seventeenth. After that it drains the store and confirms that the sixteenth entry is the last one kept and that the seventeenth was dropped. At every fill level from 1 to 16, the bench also sweeps all four trigger levels with flow control on and off. This checks the request and ready-to-send outputs against the level it has counted itself. The time-out check holds one unread character through a measured quiet period and checks `timeout_o` just before and just after four character times have passed.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
  typedef struct packed {
    logic       brk;
    logic       frm;
    logic       par;
    logic [7:0] data;
  } rx_entry_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_START, ST_DATA, ST_PAR, ST_STOP, ST_WAITHI
  } rx_state_e;
endpackage

// File: rtl/rxf_baud.sv
module rxf_baud #(
  parameter int DIV_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q;

  assign tick_o = (div_i != '0) && (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (div_i == '0)     cnt_q <= '0;
    else if (cnt_q == '0)     cnt_q <= div_i - DIV_W'(1);
    else if (cnt_q >= div_i)  cnt_q <= div_i - DIV_W'(1);
    else                      cnt_q <= cnt_q - DIV_W'(1);
  end

  // R1: consecutive enables are spaced by the divisor
  p_tick_spacing_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o && (div_i > DIV_W'(1)) && $stable(div_i) |=> !tick_o);
endmodule

// File: rtl/rxf_deframe.sv
module rxf_deframe
  import rxf_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      tick_i,
  input  logic      rx_i,
  input  logic [1:0] char_len_i,
  input  logic      parity_en_i,
  input  logic      parity_odd_i,
  output logic      push_o,
  output rx_entry_t entry_o
);
  logic [1:0] sync_q;
  logic       rxs;
  rx_state_e  state_q;
  logic [3:0] sub_q;
  logic [2:0] idx_q;
  logic [7:0] sh_q;
  logic       zero_q;
  logic       par_q;
  logic [3:0] nbits;
  logic       smp, bend, last_bit;

  assign rxs      = sync_q[1];
  assign nbits    = {2'b00, char_len_i} + 4'd5;
  assign smp      = tick_i && (sub_q == 4'd7);
  assign bend     = tick_i && (sub_q == 4'd15);
  assign last_bit = ({1'b0, idx_q} == nbits - 4'd1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= 2'b11;
    else         sync_q <= {sync_q[0], rx_i};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      sub_q   <= '0;
      idx_q   <= '0;
      sh_q    <= '0;
      zero_q  <= 1'b0;
      par_q   <= 1'b0;
      push_o  <= 1'b0;
      entry_o <= '0;
    end else begin
      push_o <= 1'b0;
      if (tick_i && state_q != ST_IDLE) sub_q <= sub_q + 4'd1;
      unique case (state_q)
        ST_IDLE: if (tick_i && !rxs) begin
          state_q <= ST_START;
          sub_q   <= '0;
          sh_q    <= '0;
          zero_q  <= 1'b1;
          par_q   <= 1'b0;
        end
        ST_START: begin
          if (smp && rxs) state_q <= ST_IDLE;  // false start
          else if (bend) begin
            state_q <= ST_DATA;
            idx_q   <= '0;
          end
        end
        ST_DATA: begin
          if (smp) begin
            sh_q[idx_q] <= rxs;
            if (rxs) zero_q <= 1'b0;
          end
          if (bend) begin
            if (last_bit) state_q <= parity_en_i ? ST_PAR : ST_STOP;
            else          idx_q   <= idx_q + 3'd1;
          end
        end
        ST_PAR: begin
          if (smp) begin
            par_q <= rxs;
            if (rxs) zero_q <= 1'b0;
          end
          if (bend) state_q <= ST_STOP;
        end
        ST_STOP: if (smp) begin
          push_o       <= 1'b1;
          entry_o.data <= sh_q;
          entry_o.frm  <= !rxs;
          entry_o.brk  <= zero_q && !rxs;
          entry_o.par  <= parity_en_i && (par_q ^ (^sh_q) ^ parity_odd_i);
          state_q      <= rxs ? ST_IDLE : ST_WAITHI;
        end
        ST_WAITHI: if (rxs) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // R3: the bit index never passes the configured length
  p_idx_bound_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ST_DATA |-> {1'b0, idx_q} < nbits);
  // R5: a character is only emitted from the stop-bit sample
  p_push_from_stop_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_o |-> $past(state_q) == ST_STOP);
  // R6: a break character always carries a framing error
  p_brk_frm_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_o && entry_o.brk |-> entry_o.frm && entry_o.data == 8'h00);
endmodule

// File: rtl/rxf_fifo.sv
module rxf_fifo
  import rxf_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = AW + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  rx_entry_t     wdata_i,
  input  logic          pop_i,
  output rx_entry_t     head_o,
  output logic [CW-1:0] count_o,
  output logic          ovf_o
);
  rx_entry_t     mem_q [DEPTH];
  logic [AW-1:0] wp_q, rp_q;
  logic          full, empty, do_push, do_pop;

  assign full    = (count_o == CW'(DEPTH));
  assign empty   = (count_o == '0);
  assign do_push = push_i && !full;
  assign do_pop  = pop_i && !empty;
  assign ovf_o   = push_i && full;
  assign head_o  = mem_q[rp_q];

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wp_q] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q    <= '0;
      rp_q    <= '0;
      count_o <= '0;
    end else begin
      if (do_push) wp_q <= nxt(wp_q);
      if (do_pop)  rp_q <= nxt(rp_q);
      count_o <= count_o + CW'(do_push) - CW'(do_pop);
    end
  end

  p_no_overflow_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_o <= CW'(DEPTH));
  p_pop_empty_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i && empty && !push_i |=> count_o == '0);
endmodule

// File: rtl/rx_framer.sv
module rx_framer
  import rxf_pkg::*;
#(
  parameter int DIV_W    = 16,
  parameter int DEPTH    = 16,
  parameter int TO_CHARS = 4,
  localparam int CW   = $clog2(DEPTH) + 1,
  localparam int TO_W = $clog2(TO_CHARS * 16 * 11 + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [DIV_W-1:0] divisor_i,
  input  logic [1:0]       char_len_i,
  input  logic             parity_en_i,
  input  logic             parity_odd_i,
  input  logic [1:0]       trig_sel_i,
  input  logic             flow_en_i,
  input  logic             rx_i,
  input  logic             rd_i,
  input  logic             status_rd_i,
  output logic [7:0]       data_o,
  output logic             par_err_o,
  output logic             frm_err_o,
  output logic             brk_o,
  output logic             empty_o,
  output logic [CW-1:0]    level_o,
  output logic             overrun_o,
  output logic             req_o,
  output logic             timeout_o,
  output logic             rts_o
);
  logic            tick, push, ovf, at_trig;
  rx_entry_t       entry, head;
  logic [CW-1:0]   trig_lvl;
  logic [3:0]      frame_bits;
  logic [TO_W-1:0] to_lim, to_cnt_q;

  rxf_baud #(.DIV_W(DIV_W)) u_baud (
    .clk_i(clk_i), .rst_ni(rst_ni), .div_i(divisor_i), .tick_o(tick)
  );

  rxf_deframe u_deframe (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick), .rx_i(rx_i),
    .char_len_i(char_len_i), .parity_en_i(parity_en_i),
    .parity_odd_i(parity_odd_i), .push_o(push), .entry_o(entry)
  );

  rxf_fifo #(.DEPTH(DEPTH)) u_fifo (
    .clk_i(clk_i), .rst_ni(rst_ni), .push_i(push), .wdata_i(entry),
    .pop_i(rd_i), .head_o(head), .count_o(level_o), .ovf_o(ovf)
  );

  assign data_o    = head.data;
  assign par_err_o = head.par;
  assign frm_err_o = head.frm;
  assign brk_o     = head.brk;
  assign empty_o   = (level_o == '0);

  always_comb begin
    unique case (trig_sel_i)
      2'd0:    trig_lvl = CW'(1);
      2'd1:    trig_lvl = CW'(4);
      2'd2:    trig_lvl = CW'(8);
      default: trig_lvl = CW'(14);
    endcase
  end

  assign at_trig = (level_o >= trig_lvl);
  assign rts_o   = !(flow_en_i && at_trig);
  assign req_o   = at_trig || timeout_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          overrun_o <= 1'b0;
    else if (ovf)         overrun_o <= 1'b1;
    else if (status_rd_i) overrun_o <= 1'b0;
  end

  // quiet-period limit in sub-bit enables
  assign frame_bits = {2'b00, char_len_i} + 4'd7 + {3'b000, parity_en_i};
  assign to_lim     = TO_W'(TO_CHARS * 16) * TO_W'(frame_bits);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) to_cnt_q <= '0;
    else if (empty_o || push || (rd_i && !empty_o)) to_cnt_q <= '0;
    else if (tick && to_cnt_q < to_lim) to_cnt_q <= to_cnt_q + TO_W'(1);
  end

  assign timeout_o = !empty_o && (to_cnt_q >= to_lim);

  p_ovr_set_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf |=> overrun_o);
  p_to_clr_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i && level_o == CW'(1) && !push |=> !timeout_o);
endmodule

// File: tb/tb_rx_framer.sv
module tb_rx_framer;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [15:0] divisor = 16'd2;
  logic [1:0] char_len = 2'd3, trig_sel = 2'd0;
  logic par_en = 1'b0, par_odd = 1'b0, flow_en = 1'b0;
  logic rx = 1'b1, rd = 1'b0, srd = 1'b0;
  logic [7:0] data;
  logic par_err, frm_err, brk, empty, overrun, req, tmo, rts;
  logic [4:0] level;

  int checks = 0, fails = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rx_framer dut (
    .clk_i(clk), .rst_ni(rst_n), .divisor_i(divisor), .char_len_i(char_len),
    .parity_en_i(par_en), .parity_odd_i(par_odd), .trig_sel_i(trig_sel),
    .flow_en_i(flow_en), .rx_i(rx), .rd_i(rd), .status_rd_i(srd),
    .data_o(data), .par_err_o(par_err), .frm_err_o(frm_err), .brk_o(brk),
    .empty_o(empty), .level_o(level), .overrun_o(overrun), .req_o(req),
    .timeout_o(tmo), .rts_o(rts)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // drive one frame; bit time taken from bdiv
  task automatic send(input logic [7:0] d, input int nb, input bit pe, input bit po,
                      input bit pflip, input bit stop_hi, input int bdiv);
    int bc = 16 * bdiv;
    logic p = po;
    @(negedge clk);
    rx = 1'b0; wait_cyc(bc);
    for (int i = 0; i < nb; i++) begin
      rx = d[i]; p = p ^ d[i]; wait_cyc(bc);
    end
    if (pe) begin rx = p ^ pflip; wait_cyc(bc); end
    rx = stop_hi; wait_cyc(bc);
    rx = 1'b1; wait_cyc(stop_hi ? bc : 2 * bc);
  endtask

  task automatic pop;
    rd = 1'b1; @(negedge clk); rd = 1'b0;
  endtask

  task automatic check_head(input logic [7:0] ed, input bit ep, input bit ef,
                            input bit eb, input string tag);
    chk(!empty, {tag, " not empty"}, empty, 0);
    chk(data == ed, {tag, " data"}, data, ed);
    chk(par_err == ep, {tag, " par_err"}, par_err, ep);
    chk(frm_err == ef, {tag, " frm_err"}, frm_err, ef);
    chk(brk == eb, {tag, " brk"}, brk, eb);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    int trig_tab [4] = '{1, 4, 8, 14};
    wait_cyc(3);
    // reset state (R7, R8, R9, R10, R11)
    chk(level == 0 && empty, "R7 reset level", level, 0);
    chk(!overrun, "R8 reset overrun", overrun, 0);
    chk(!req, "R9 reset req", req, 0);
    chk(rts, "R10 reset rts", rts, 1);
    chk(!tmo, "R11 reset timeout", tmo, 0);
    rst_n = 1'b1;
    wait_cyc(4);

    // R3/R4 sweep: lengths x parity modes x data values
    for (int nb = 5; nb <= 8; nb++)
      for (int pm = 0; pm < 3; pm++)
        for (int k = 0; k < 8; k++) begin
          logic [7:0] mask = 8'((1 << nb) - 1);
          logic [7:0] d = (k == 0) ? 8'h00 : (k == 1) ? mask : 8'((k * 37 + 5 + nb) & mask);
          char_len = 2'(nb - 5); par_en = (pm != 0); par_odd = (pm == 2);
          send(d, nb, par_en, par_odd, 0, 1, 2);
          check_head(d, 0, 0, 0, "R3 sweep");
          pop;
        end

    // R4 wrong parity, even and odd, and R5 only the first stop bit
    char_len = 2'd3; par_en = 1; par_odd = 0;
    send(8'hA5, 8, 1, 0, 1, 1, 2);
    check_head(8'hA5, 1, 0, 0, "R4 even bad"); pop;
    par_odd = 1;
    send(8'h3C, 8, 1, 1, 1, 1, 2);
    check_head(8'h3C, 1, 0, 0, "R4 odd bad"); pop;
    par_en = 0;

    // R5 low stop bit
    send(8'h5A, 8, 0, 0, 0, 0, 2);
    check_head(8'h5A, 0, 1, 0, "R5 framing");
    chk(level == 1, "R5 single entry", level, 1); pop;

    // R6 break: line low for two character times
    @(negedge clk); rx = 0; wait_cyc(2 * 10 * 32); rx = 1; wait_cyc(64);
    chk(level == 1, "R6 break once", level, 1);
    check_head(8'h00, 0, 1, 1, "R6 break"); pop;

    // R2 short low glitch
    @(negedge clk); rx = 0; wait_cyc(3 * 2); rx = 1; wait_cyc(400);
    chk(level == 0, "R2 glitch ignored", level, 0);

    // R1 divisor 0 stops reception, other divisors work
    divisor = 0;
    send(8'h77, 8, 0, 0, 0, 1, 2); wait_cyc(100);
    chk(level == 0, "R1 divisor zero", level, 0);
    divisor = 3;
    send(8'hC3, 8, 0, 0, 0, 1, 3);
    check_head(8'hC3, 0, 0, 0, "R1 divisor 3"); pop;
    divisor = 1;
    send(8'h96, 8, 0, 0, 0, 1, 1);
    check_head(8'h96, 0, 0, 0, "R1 divisor 1"); pop;

    // R7 pop on empty has no effect
    pop; wait_cyc(2);
    chk(level == 0 && empty, "R7 pop empty", level, 0);

    // fill 16, sweeping trigger and flow at every level (R9, R10)
    for (int n = 1; n <= 16; n++) begin
      send(8'(n * 11), 8, 0, 0, 0, 1, 1);
      chk(level == 5'(n), "R7 level count", level, n);
      for (int t = 0; t < 4; t++)
        for (int f = 0; f < 2; f++) begin
          trig_sel = 2'(t); flow_en = f[0]; #1;
          chk(req == (n >= trig_tab[t]), "R9 req", req, n >= trig_tab[t]);
          chk(rts == !(f == 1 && n >= trig_tab[t]), "R10 rts", rts,
              !(f == 1 && n >= trig_tab[t]));
        end
    end
    flow_en = 0; trig_sel = 2'd3;
    // R8 overrun
    chk(!overrun, "R8 no overrun yet", overrun, 0);
    send(8'hEE, 8, 0, 0, 0, 1, 1);
    chk(overrun, "R8 overrun set", overrun, 1);
    chk(level == 16, "R8 level held", level, 16);
    for (int n = 1; n <= 16; n++) begin
      check_head(8'(n * 11), 0, 0, 0, "R7 order"); pop;
    end
    chk(empty, "R8 extra dropped", level, 0);
    chk(overrun, "R8 overrun sticky", overrun, 1);
    srd = 1; @(negedge clk); srd = 0;
    chk(!overrun, "R8 overrun cleared", overrun, 0);

    // R11 time-out: 8 bits no parity, divisor 1 -> 640 enables
    send(8'h42, 8, 0, 0, 0, 1, 1); // returns ~16+ cycles after the push
    wait_cyc(560);
    chk(!tmo, "R11 before limit", tmo, 0);
    chk(!req, "R9 no req before timeout", req, 0);
    wait_cyc(120);
    chk(tmo, "R11 after limit", tmo, 1);
    chk(req, "R9 req from timeout", req, 1);
    pop; #1;
    chk(!tmo, "R11 cleared by read", tmo, 0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule